// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit system control registers on a simple register bus. The bus carries a byte address, a write strobe with write data, and a read strobe. Read data appears one clock after the read strobe. The bank decodes a 4 KiB region and accepts aligned word accesses only, so the two low address bits are ignored. The word index is the byte offset shifted right by two. Accesses beyond the register array do nothing, and reads there return zero.

Most control words at low offsets are guarded by a key word at offset 0x00. Writing the unlock constant there stores 1 and opens the bank. Writing any other value stores 0 and closes it. While the bank is closed, writes to offsets 0x04 up to and including 0x100 are dropped. Offset 0x104 and everything above it stay writable.

Some words are read-only:
- the frequency measurement result,
- the eight scratch words,
- the random word,
- the two free-running counter words.

A hardware-strap word at 0x70 is handled according to the silicon-revision parameter. On the newer revision, writes to 0x70 set bits, and writes to the revision word at 0x7C clear bits of the strap word. On the older revision, writes to 0x70 replace the strap word, and writes to 0x7C have no effect. Reading offset 0x78 returns a fresh pseudo-random word on every read. The reset contents come from per-revision constants, together with parameters for the revision word, both strap words and the key word.

Top module: `keyed_ctl_regs`

## Requirements
- R1: After reset the key word (0x00) holds the KEY_INIT parameter. The revision word (0x7C) holds REV_ID, and the strap words at 0x70 and 0xD0 hold STRAP_A_INIT and STRAP_B_INIT. Other words take per-revision constants: 0x04 reads 0xFFCFFEDC and 0x40 reads 0x000000C0 on both revisions. 0x24 reads 0x93000400 on the newer revision and 0x00000291 on the older one. Offsets with no defined constant, such as 0x100, read 0.
- R2: A write of UNLOCK_KEY (default 0x1688A8A8) to offset 0x00 makes the key word read 1. A write of any other value makes it read 0.
- R3: While the key word reads 0, writes to offsets 0x04 through 0x100 leave the addressed word unchanged. Writes at 0x104 and above take effect whatever the key word holds.
- R4: Writes to offsets 0x14, 0x50 through 0x6C, 0x78, 0xE0 and 0xE4 never change the word read back, even with the bank open. 0xE0 and 0xE4 keep reading 0x000000FF.
- R5: Every read of offset 0x78 returns a value different from the previous read of 0x78. This holds whatever is stored at 0x74.
- R6: Newer revision: a write to 0x70 ORs the data into the strap word. A write to 0x7C clears the strap bits that are 1 in the data. The revision word never changes.
- R7: Older revision: a write to 0x70 replaces the strap word, and a write to 0x7C changes no word.
- R8: Writes with a word index at or above NUM_REGS change nothing, and reads there return 0.
- R9: Open offsets with no special rule read back the last value written to them.
- R10: Read data is valid in the cycle after the read strobe. A read and a write to the same word in one cycle return the value the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address; bits [1:0] ignored |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, one cycle after busRdEn |

## Verification
The hardest state to reach is the key being closed again after it has been opened. A protected word must then keep a value written while the bank was open, and later writes to it must be dropped. The stimulus walks the bank through closed, open and wrong-key states. It writes the same protected word in each state and reads it back every time.

The strap behaviour depends on the revision, so two instances with different revision parameters share one bus. Each gets its own expected values. The random word is checked against its own previous read, not against a fixed value.

// File: rtl/keyed_ctl_pkg.sv
package keyed_ctl_pkg;

  // Word indices whose position is part of the block's behaviour.
  localparam int unsigned IDX_KEY       = 0;
  localparam int unsigned IDX_FREQ_RES  = 5;
  localparam int unsigned IDX_SCR_FIRST = 20;
  localparam int unsigned IDX_SCR_LAST  = 27;
  localparam int unsigned IDX_STRAP_A   = 28;
  localparam int unsigned IDX_RAND      = 30;
  localparam int unsigned IDX_REV       = 31;
  localparam int unsigned IDX_STRAP_B   = 52;
  localparam int unsigned IDX_CNT_LO    = 56;
  localparam int unsigned IDX_CNT_HI    = 57;
  localparam int unsigned IDX_OPEN_FROM = 65;

  // Strobes from the decoder to the storage.
  typedef struct packed {
    logic inRange;
    logic doKey;
    logic doStore;
    logic doStrapOr;
    logic doStrapClr;
    logic doRand;
    logic doRead;
  } strobe_t;

  // Per-revision reset constant for a word index.
  function automatic logic [31:0] resetWord(int unsigned idx, bit newer);
    logic [31:0] w;
    w = 32'h0;
    case (idx)
      16:  w = 32'h0000_00C0;
      1:   w = 32'hFFCF_FEDC;
      9:   w = newer ? 32'h9300_0400 : 32'h0000_0291;
      56, 57: w = 32'h0000_00FF;
      29:  w = 32'h0000_000E;
      2:   w = 32'hF3F4_0000;
      8:   w = 32'h0003_0291;
      3:   w = 32'h19FC_3E8B;
      7:   w = 32'h0002_6108;
      12, 13: w = 32'h2000_1A03;
      11:  w = 32'h0000_0010;
      14:  w = 32'h0400_0030;
      15:  w = 32'h0000_0001;
      19:  w = 32'h0000_0023;
      34:  w = newer ? 32'h0300_0000 : 32'h0100_0000;
      33:  w = 32'h0000_F000;
      35:  w = newer ? 32'h0000_0000 : 32'h0000_00FF;
      36:  w = 32'h0000_A000;
      39:  w = newer ? 32'h023F_FFF3 : 32'h003F_FFF3;
      42:  w = 32'h000F_FFFF;
      41:  w = 32'hFFFF_0000;
      68:  w = 32'h1E60_0000;
      65:  w = 32'h8000_0000;
      69:  w = 32'hC000_0000;
      96:  w = 32'h0000_007B;
      88:  w = 32'h0000_1903;
      105: w = 32'h0000_2402;
      default: w = 32'h0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/keyed_ctl_decode.sv
module keyed_ctl_decode
  import keyed_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_REGS  = 128,
  parameter bit          NEWER_REV = 1'b1,
  localparam int unsigned IDX_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              unlocked,
  output logic [IDX_W-1:0]  wordIdx,
  output strobe_t           strobe
);

  logic [1:0]  unusedLowBits;
  int unsigned idxU;
  logic        inRange;
  logic        guarded;
  logic        readOnly;
  logic        wrOk;

  assign unusedLowBits = busAddr[1:0];
  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign idxU          = 32'(wordIdx);
  assign inRange       = idxU < NUM_REGS;

  // Protected window: above the key word, below the always-open region.
  assign guarded  = (idxU != IDX_KEY) && (idxU < IDX_OPEN_FROM);

  assign readOnly = (idxU == IDX_FREQ_RES)
                  || ((idxU >= IDX_SCR_FIRST) && (idxU <= IDX_SCR_LAST))
                  || (idxU == IDX_RAND)
                  || (idxU == IDX_CNT_LO)
                  || (idxU == IDX_CNT_HI);

  assign wrOk = busWrEn && inRange && !(guarded && !unlocked);

  always_comb begin
    strobe            = '0;
    strobe.inRange    = inRange;
    strobe.doRead     = busRdEn;
    strobe.doRand     = busRdEn && inRange && (idxU == IDX_RAND);
    strobe.doKey      = wrOk && (idxU == IDX_KEY);
    strobe.doStrapOr  = wrOk && NEWER_REV && (idxU == IDX_STRAP_A);
    strobe.doStrapClr = wrOk && NEWER_REV && (idxU == IDX_REV);
    strobe.doStore    = wrOk && (idxU != IDX_KEY) && !readOnly
                      && (idxU != IDX_REV)
                      && !(NEWER_REV && (idxU == IDX_STRAP_A));
  end

endmodule

// File: rtl/keyed_ctl_store.sv
module keyed_ctl_store
  import keyed_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned NUM_REGS     = 128,
  parameter bit          NEWER_REV    = 1'b1,
  parameter logic [31:0] UNLOCK_KEY   = 32'h1688_A8A8,
  parameter logic [31:0] KEY_INIT     = 32'h0,
  parameter logic [31:0] REV_ID       = 32'h0403_0303,
  parameter logic [31:0] STRAP_A_INIT = 32'h0,
  parameter logic [31:0] STRAP_B_INIT = 32'h0,
  parameter logic [31:0] LFSR_SEED    = 32'hACE1_2468,
  localparam int unsigned IDX_W       = ADDR_W - 2,
  localparam int unsigned RIW         = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [31:0]      busWrData,
  input  strobe_t          strobe,
  output logic             unlocked,
  output logic [31:0]      lfsrState,
  output logic [31:0]      busRdData
);

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  logic [31:0]    regsQ [NUM_REGS];
  logic [31:0]    lfsrQ;
  logic [31:0]    lfsrNext;
  logic [RIW-1:0] sel;

  assign sel       = wordIdx[RIW-1:0];
  assign unlocked  = regsQ[RIW'(IDX_KEY)] != 32'h0;
  assign lfsrState = lfsrQ;
  assign lfsrNext  = (lfsrQ >> 1) ^ (lfsrQ[0] ? LFSR_TAPS : 32'h0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regsQ[RIW'(i)] <= resetWord(i, NEWER_REV);
      end
      regsQ[RIW'(IDX_KEY)]     <= KEY_INIT;
      regsQ[RIW'(IDX_REV)]     <= REV_ID;
      regsQ[RIW'(IDX_STRAP_A)] <= STRAP_A_INIT;
      regsQ[RIW'(IDX_STRAP_B)] <= STRAP_B_INIT;
    end else begin
      if (strobe.doKey) begin
        regsQ[RIW'(IDX_KEY)] <= (busWrData == UNLOCK_KEY) ? 32'h1 : 32'h0;
      end
      if (strobe.doStore) begin
        regsQ[sel] <= busWrData;
      end
      if (strobe.doStrapOr) begin
        regsQ[RIW'(IDX_STRAP_A)] <= regsQ[RIW'(IDX_STRAP_A)] | busWrData;
      end
      if (strobe.doStrapClr) begin
        regsQ[RIW'(IDX_STRAP_A)] <= regsQ[RIW'(IDX_STRAP_A)] & ~busWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
    end else if (strobe.doRand) begin
      lfsrQ <= lfsrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= 32'h0;
    end else if (strobe.doRead) begin
      if (strobe.doRand) begin
        busRdData <= lfsrNext;
      end else if (strobe.inRange) begin
        busRdData <= regsQ[sel];
      end else begin
        busRdData <= 32'h0;
      end
    end
  end

endmodule

// File: rtl/keyed_ctl_regs.sv
module keyed_ctl_regs
  import keyed_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned NUM_REGS     = 128,
  parameter bit          NEWER_REV    = 1'b1,
  parameter logic [31:0] UNLOCK_KEY   = 32'h1688_A8A8,
  parameter logic [31:0] KEY_INIT     = 32'h0,
  parameter logic [31:0] REV_ID       = 32'h0403_0303,
  parameter logic [31:0] STRAP_A_INIT = 32'h0,
  parameter logic [31:0] STRAP_B_INIT = 32'h0,
  parameter logic [31:0] LFSR_SEED    = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  strobe_t          strobe;
  logic             unlocked;
  logic [31:0]      lfsrState;

  keyed_ctl_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NEWER_REV(NEWER_REV)
  ) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .unlocked(unlocked),
    .wordIdx (wordIdx),
    .strobe  (strobe)
  );

  keyed_ctl_store #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NEWER_REV(NEWER_REV),
    .UNLOCK_KEY(UNLOCK_KEY), .KEY_INIT(KEY_INIT), .REV_ID(REV_ID),
    .STRAP_A_INIT(STRAP_A_INIT), .STRAP_B_INIT(STRAP_B_INIT),
    .LFSR_SEED(LFSR_SEED)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .wordIdx  (wordIdx),
    .busWrData(busWrData),
    .strobe   (strobe),
    .unlocked (unlocked),
    .lfsrState(lfsrState),
    .busRdData(busRdData)
  );

endmodule

// File: rtl/keyed_ctl_regs_chk.sv
module keyed_ctl_regs_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_REGS   = 128,
  parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8,
  parameter logic [31:0] REV_ID     = 32'h0403_0303
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic              busRdEn,
  input logic [31:0]       busRdData,
  input logic              unlocked,
  input logic [31:0]       lfsrState
);

  logic [31:0] idxW;
  assign idxW = 32'(busAddr[ADDR_W-1:2]);

  // R2: the unlock constant opens the bank on the next cycle
  p_key_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && idxW == 0 && busWrData == UNLOCK_KEY) |=> unlocked);

  // R2: any other value closes it
  p_key_shut_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && idxW == 0 && busWrData != UNLOCK_KEY) |=> !unlocked);

  // R8: reads beyond the array return zero
  p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && idxW >= NUM_REGS) |=> busRdData == 32'h0);

  // R6 / R7: the revision word always reads its parameter
  p_rev_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && idxW == 31) |=> busRdData == REV_ID);

  // R5: each random read advances the generator
  p_rand_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && idxW == 30) |=> lfsrState != $past(lfsrState));

endmodule

bind keyed_ctl_regs keyed_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
  .UNLOCK_KEY(UNLOCK_KEY), .REV_ID(REV_ID)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdEn  (busRdEn),
  .busRdData(busRdData),
  .unlocked (unlocked),
  .lfsrState(lfsrState)
);

// File: tb/tb_keyed_ctl_regs.sv
module tb_keyed_ctl_regs;

  localparam logic [31:0] KEY     = 32'h1688_A8A8;
  localparam logic [31:0] REV_NEW = 32'h0403_0303;
  localparam logic [31:0] REV_OLD = 32'h0201_0303;
  localparam logic [31:0] SA_NEW  = 32'h00F0_0000;
  localparam logic [31:0] SA_OLD  = 32'h0000_0F0F;
  localparam logic [31:0] SB_NEW  = 32'h0000_0011;
  localparam logic [31:0] SB_OLD  = 32'h0000_0022;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] rdNew;
  logic [31:0] rdOld;

  always #10 clk = ~clk;

  keyed_ctl_regs #(
    .NEWER_REV(1'b1), .UNLOCK_KEY(KEY), .KEY_INIT(32'h0), .REV_ID(REV_NEW),
    .STRAP_A_INIT(SA_NEW), .STRAP_B_INIT(SB_NEW)
  ) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rdNew)
  );

  keyed_ctl_regs #(
    .NEWER_REV(1'b0), .UNLOCK_KEY(KEY), .KEY_INIT(32'h0), .REV_ID(REV_OLD),
    .STRAP_A_INIT(SA_OLD), .STRAP_B_INIT(SB_OLD)
  ) dutOld (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rdOld)
  );

  typedef struct {
    logic [31:0] eNew;
    logic [31:0] eOld;
    bit          isRand;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          vectors = 0;
  int          misses = 0;
  logic        issued = 1'b0;
  logic [31:0] lastRandNew = '0;
  logic [31:0] lastRandOld = '0;
  bit          finished = 1'b0;

  // Monitor: read data valid the cycle after the strobe (R10)
  always @(posedge clk) issued <= busRdEn;

  always @(negedge clk) begin
    if (issued && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors += 2;
      if (it.isRand) begin
        if (rdNew == lastRandNew) begin
          misses++;
          $display("FAIL %s new-rev: got %h, expected a value other than %h", it.tag, rdNew, lastRandNew);
        end
        if (rdOld == lastRandOld) begin
          misses++;
          $display("FAIL %s old-rev: got %h, expected a value other than %h", it.tag, rdOld, lastRandOld);
        end
        lastRandNew = rdNew;
        lastRandOld = rdOld;
      end else begin
        if (rdNew !== it.eNew) begin
          misses++;
          $display("FAIL %s new-rev: got %h expected %h", it.tag, rdNew, it.eNew);
        end
        if (rdOld !== it.eOld) begin
          misses++;
          $display("FAIL %s old-rev: got %h expected %h", it.tag, rdOld, it.eOld);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] eN,
                    input logic [31:0] eO, input string tag);
    item_t it;
    it.eNew = eN; it.eOld = eO; it.isRand = 1'b0; it.tag = tag;
    sb.push_back(it);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rdRand(input string tag);
    item_t it;
    it.eNew = '0; it.eOld = '0; it.isRand = 1'b1; it.tag = tag;
    sb.push_back(it);
    busAddr = 12'h078; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rdWr(input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] eN, input logic [31:0] eO, input string tag);
    item_t it;
    it.eNew = eN; it.eOld = eO; it.isRand = 1'b0; it.tag = tag;
    sb.push_back(it);
    busAddr = a; busWrData = d; busRdEn = 1'b1; busWrEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0; busWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset contents
    rd(12'h000, 32'h0, 32'h0, "R1 key");
    rd(12'h004, 32'hFFCF_FEDC, 32'hFFCF_FEDC, "R1 0x04");
    rd(12'h040, 32'h0000_00C0, 32'h0000_00C0, "R1 0x40");
    rd(12'h024, 32'h9300_0400, 32'h0000_0291, "R1 0x24");
    rd(12'h07C, REV_NEW, REV_OLD, "R1 rev");
    rd(12'h070, SA_NEW, SA_OLD, "R1 strapA");
    rd(12'h0D0, SB_NEW, SB_OLD, "R1 strapB");
    rd(12'h100, 32'h0, 32'h0, "R1 undefined");

    // R3: locked bank drops protected writes, keeps open region writable
    wr(12'h040, 32'h0000_1234);
    rd(12'h040, 32'h0000_00C0, 32'h0000_00C0, "R3 locked drop");
    wr(12'h104, 32'h0000_CAFE);
    rd(12'h104, 32'h0000_CAFE, 32'h0000_CAFE, "R3 open while locked");
    wr(12'h180, 32'h0000_0055);
    rd(12'h180, 32'h0000_0055, 32'h0000_0055, "R9 readback");

    // R2: key handling
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h000, 32'h0, 32'h0, "R2 wrong key");
    wr(12'h000, KEY);
    rd(12'h000, 32'h1, 32'h1, "R2 magic key");
    wr(12'h040, 32'h0000_1234);
    rd(12'h040, 32'h0000_1234, 32'h0000_1234, "R3 unlocked write");
    wr(12'h0A0, 32'h0BAD_F00D);
    rd(12'h0A0, 32'h0BAD_F00D, 32'h0BAD_F00D, "R9 protected readback");

    // R4: read-only words
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h050, 32'hFFFF_FFFF);
    wr(12'h06C, 32'hFFFF_FFFF);
    wr(12'h0E0, 32'hFFFF_FFFF);
    wr(12'h0E4, 32'hFFFF_FFFF);
    rd(12'h014, 32'h0, 32'h0, "R4 freq result");
    rd(12'h050, 32'h0, 32'h0, "R4 scratch first");
    rd(12'h06C, 32'h0, 32'h0, "R4 scratch last");
    rd(12'h0E0, 32'hFF, 32'hFF, "R4 counter lo");
    rd(12'h0E4, 32'hFF, 32'hFF, "R4 counter hi");

    // R6 / R7: strap paths
    wr(12'h070, 32'h0000_000F);
    rd(12'h070, SA_NEW | 32'hF, 32'h0000_000F, "R6 R7 strap write");
    wr(12'h07C, 32'h0030_0005);
    rd(12'h070, (SA_NEW | 32'hF) & ~32'h0030_0005, 32'h0000_000F, "R6 R7 strap clear");
    rd(12'h07C, REV_NEW, REV_OLD, "R6 R7 rev unchanged");

    // R5: random word with the enable word cleared
    wr(12'h074, 32'h0);
    rd(12'h074, 32'h0, 32'h0, "R9 enable cleared");
    rdRand("R5 rand 1");
    rdRand("R5 rand 2");
    rdRand("R5 rand 3");
    wr(12'h078, 32'h0);
    rdRand("R5 R4 rand after write");

    // R8: beyond the array
    wr(12'h204, 32'h0000_0077);
    rd(12'h204, 32'h0, 32'h0, "R8 oob write/read");
    rd(12'hFFC, 32'h0, 32'h0, "R8 top of region");
    rd(12'h004, 32'hFFCF_FEDC, 32'hFFCF_FEDC, "R8 alias untouched");

    // R10: read-during-write returns the old value
    rdWr(12'h104, 32'h0000_BEEF, 32'h0000_CAFE, 32'h0000_CAFE, "R10 read during write");
    rd(12'h104, 32'h0000_BEEF, 32'h0000_BEEF, "R10 after write");

    // R3 / R2: relock with wrong key
    wr(12'h000, 32'h0000_BEEF);
    rd(12'h000, 32'h0, 32'h0, "R2 relock");
    wr(12'h040, 32'h0000_9999);
    rd(12'h040, 32'h0000_1234, 32'h0000_1234, "R3 relocked drop");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      misses++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    finishRun();
  end

endmodule